// File: doc/BRIEF.md
# Asynchronous Static RAM Bridge with Byte Lanes

This block connects a synchronous host request bus to an external asynchronous static RAM of 1M words by 16 bits. The host presents a request (read or write, word address, write data and a per-byte lane mask) while `req_ready` is high. The bridge then drives the RAM's two opposite-polarity selects, output enable, write enable and the lower and upper byte enables. Every strobe interval is a whole number of clock cycles, computed by rounding up the RAM's minimum times (55 ns grade) against the clock-period parameter. The bridge ends each request with a single-cycle `rsp_done`, which also carries the read data.

The RAM data bus is split into an output word, a driver enable and an input word, so the pad ring can build the bidirectional pin. The bridge drives the bus only in the write states. It reaches those states only after output enable has been high long enough for the RAM to float its outputs.

The controller has six states. `ST_IDLE` accepts a request and moves to `ST_RD_WIN` (read), to `ST_WR_SETUP` (write with a non-zero mask), or stays in `ST_IDLE` and completes at once (write with a zero mask). `ST_RD_WIN` holds the read window and moves to `ST_RD_TURN` when its timer expires, capturing data and raising done. `ST_RD_TURN` keeps output enable high for the turnaround time and then returns to `ST_IDLE`. `ST_WR_SETUP` goes to `ST_WR_PULSE`, which holds write enable low. `ST_WR_PULSE` goes to `ST_WR_HOLD`, which ends the write cycle and returns to `ST_IDLE` with done.

Top module: `sram_bridge`

## Requirements
- R1: While reset is asserted and right after it: `sram_sel_n`=1, `sram_sel`=0, `sram_oe_n`=1, `sram_we_n`=1, `sram_be_n`=2'b11, `sram_dq_oe`=0, `rsp_done`=0 and `req_ready`=1.
- R2: `sram_sel_n` and `sram_sel` always show the same select state (`sram_sel_n` = not `sram_sel`). Output enable or write enable is asserted only while the RAM is selected.
- R3: A read holds `sram_oe_n` low, `sram_we_n` high and the address stable for RD_CYC = ceil(55 ns / period) cycles. Data is sampled at the clock edge that closes the window. Output enable and write enable are never low together.
- R4: For a read, mask bit 0 lowers `sram_be_n[0]` (data bits 7:0) and mask bit 1 lowers `sram_be_n[1]` (bits 15:8). A lane whose mask bit is 0 returns 0 in `rsp_rdata`.
- R5: A write asserts the select, the byte enables and the address for SU_CYC cycles with `sram_we_n` high. It then holds `sram_we_n` low for WE_CYC = max(ceil(40 ns/period), ceil(25 ns/period)) cycles, then holds HD_CYC cycles with `sram_we_n` high. SU_CYC = max(1, ceil(45 ns/period) − WE_CYC) and HD_CYC = max(1, ceil(55 ns/period) − SU_CYC − WE_CYC). Output enable stays high throughout.
- R6: `sram_dq_oe` is high only in the write states and never while `sram_oe_n` is low. It rises no sooner than TA_CYC = ceil(20 ns/period) cycles after `sram_oe_n` rose.
- R7: A write with mask 2'b00 completes with `rsp_done` on the next cycle. It never lowers `sram_we_n` and leaves the RAM contents unchanged.
- R8: `rsp_done` is a one-cycle pulse. A request is accepted only in a cycle where `req_ready` is high, and `req_valid` in any other cycle has no effect.
- R9: A write stores exactly the lanes selected by its mask at its address. Read-back returns the merged contents.
- R10: Counting from the accept edge to the cycle where `rsp_done` is high, a read takes RD_CYC cycles, a write with a non-zero mask takes SU_CYC+WE_CYC+HD_CYC cycles and a zero-mask write takes 0 cycles. With the default 10 ns period these are 6 and 1+4+1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Bridge can accept a request this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Word address |
| req_wdata | input | DATA_W | Write data |
| req_mask | input | DATA_W/8 | Byte-lane mask, bit 0 = bits 7:0 |
| rsp_done | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | DATA_W | Read data, valid with rsp_done after a read |
| sram_addr | output | ADDR_W | RAM address |
| sram_sel_n | output | 1 | Active-low RAM select |
| sram_sel | output | 1 | Active-high RAM select |
| sram_oe_n | output | 1 | Active-low output enable |
| sram_we_n | output | 1 | Active-low write enable |
| sram_be_n | output | DATA_W/8 | Active-low byte enables, bit 0 = lower byte |
| sram_dq_out | output | DATA_W | Data driven to the RAM |
| sram_dq_oe | output | 1 | Enables the data drivers |
| sram_dq_in | input | DATA_W | Data seen on the RAM bus |

## Verification
The bench builds the bridge with `CLK_PERIOD_PS` = 20000, so the parameters give a 3-cycle read, a 1+2+1 write and a 1-cycle turnaround. At this period the write needs the minimum hold cycle beyond the rounded 55 ns cycle. The turnaround is at its smallest count, which puts the write-after-read case at its tightest margin. A cycle-accurate RAM model measures each strobe interval in nanoseconds against the 55 ns limits, flags bus contention, and checks byte-masked read-back against a reference array across random back-to-back traffic and directed corner cases.

// File: rtl/sram_bridge_pkg.sv
package sram_bridge_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RD_WIN,
        ST_RD_TURN,
        ST_WR_SETUP,
        ST_WR_PULSE,
        ST_WR_HOLD
    } bridge_state_e;

    // Minimum RAM intervals for the 55 ns grade, in picoseconds.
    localparam int unsigned T_READ_CYCLE_PS  = 55000;
    localparam int unsigned T_WE_PULSE_PS    = 40000;
    localparam int unsigned T_DATA_SETUP_PS  = 25000;
    localparam int unsigned T_LANE_TO_END_PS = 45000;
    localparam int unsigned T_WRITE_CYCLE_PS = 55000;
    localparam int unsigned T_FLOAT_PS       = 20000;

    function automatic int unsigned ps_to_cycles(input int unsigned ps,
                                                 input int unsigned period_ps);
        return (ps + period_ps - 1) / period_ps;
    endfunction

    function automatic int unsigned max_u(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/sram_interval_timer.sv
module sram_interval_timer #(
    parameter int unsigned W = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         expired
);
    logic [W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign expired = (cnt_q == '0);
endmodule

// File: rtl/sram_lane_capture.sv
module sram_lane_capture #(
    parameter int unsigned LANES = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               capture,
    input  logic [LANES-1:0]   lane_mask,
    input  logic [8*LANES-1:0] bus_in,
    output logic [8*LANES-1:0] word_out
);
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                word_out[8*g +: 8] <= '0;
            end else if (capture) begin
                word_out[8*g +: 8] <= lane_mask[g] ? bus_in[8*g +: 8] : 8'h00;
            end
        end
    end
endmodule

// File: rtl/sram_bridge.sv
module sram_bridge
    import sram_bridge_pkg::*;
#(
    parameter int unsigned ADDR_W        = 20,
    parameter int unsigned DATA_W        = 16,
    parameter int unsigned CLK_PERIOD_PS = 10000
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  req_valid,
    output logic                  req_ready,
    input  logic                  req_write,
    input  logic [ADDR_W-1:0]     req_addr,
    input  logic [DATA_W-1:0]     req_wdata,
    input  logic [DATA_W/8-1:0]   req_mask,
    output logic                  rsp_done,
    output logic [DATA_W-1:0]     rsp_rdata,
    output logic [ADDR_W-1:0]     sram_addr,
    output logic                  sram_sel_n,
    output logic                  sram_sel,
    output logic                  sram_oe_n,
    output logic                  sram_we_n,
    output logic [DATA_W/8-1:0]   sram_be_n,
    output logic [DATA_W-1:0]     sram_dq_out,
    output logic                  sram_dq_oe,
    input  logic [DATA_W-1:0]     sram_dq_in
);
    localparam int unsigned LANES   = DATA_W / 8;
    localparam int unsigned RD_CYC  = max_u(1, ps_to_cycles(T_READ_CYCLE_PS, CLK_PERIOD_PS));
    localparam int unsigned WE_CYC  = max_u(1, max_u(ps_to_cycles(T_WE_PULSE_PS, CLK_PERIOD_PS),
                                                     ps_to_cycles(T_DATA_SETUP_PS, CLK_PERIOD_PS)));
    localparam int unsigned BW_CYC  = ps_to_cycles(T_LANE_TO_END_PS, CLK_PERIOD_PS);
    localparam int unsigned SU_CYC  = max_u(1, (BW_CYC > WE_CYC) ? BW_CYC - WE_CYC : 0);
    localparam int unsigned WC_CYC  = ps_to_cycles(T_WRITE_CYCLE_PS, CLK_PERIOD_PS);
    localparam int unsigned HD_CYC  = max_u(1, (WC_CYC > SU_CYC + WE_CYC) ?
                                               WC_CYC - SU_CYC - WE_CYC : 0);
    localparam int unsigned TA_CYC  = max_u(1, ps_to_cycles(T_FLOAT_PS, CLK_PERIOD_PS));
    localparam int unsigned MAX_CYC = max_u(max_u(RD_CYC, WE_CYC),
                                            max_u(max_u(SU_CYC, HD_CYC), TA_CYC));
    localparam int unsigned TMR_W   = $clog2(MAX_CYC + 1);

    localparam logic [TMR_W-1:0] RD_LOAD = TMR_W'(RD_CYC - 1);
    localparam logic [TMR_W-1:0] WE_LOAD = TMR_W'(WE_CYC - 1);
    localparam logic [TMR_W-1:0] SU_LOAD = TMR_W'(SU_CYC - 1);
    localparam logic [TMR_W-1:0] HD_LOAD = TMR_W'(HD_CYC - 1);
    localparam logic [TMR_W-1:0] TA_LOAD = TMR_W'(TA_CYC - 1);

    bridge_state_e       state_q, state_nx;
    logic                accept;
    logic                tmr_load, tmr_expired;
    logic [TMR_W-1:0]    tmr_val;
    logic                cap_en, finish;
    logic                sel_nx;
    logic [ADDR_W-1:0]   addr_q, addr_nx;
    logic [DATA_W-1:0]   wdata_q, wdata_nx;
    logic [LANES-1:0]    mask_q, mask_nx;

    assign req_ready = (state_q == ST_IDLE) && !rsp_done;
    assign accept    = req_valid && req_ready;
    assign addr_nx   = accept ? req_addr  : addr_q;
    assign wdata_nx  = accept ? req_wdata : wdata_q;
    assign mask_nx   = accept ? req_mask  : mask_q;

    // Next-state decode and timer control.
    always_comb begin
        state_nx = state_q;
        tmr_load = 1'b0;
        tmr_val  = '0;
        cap_en   = 1'b0;
        finish   = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (accept) begin
                    if (!req_write) begin
                        state_nx = ST_RD_WIN;
                        tmr_load = 1'b1;
                        tmr_val  = RD_LOAD;
                    end else if (req_mask == '0) begin
                        finish = 1'b1;
                    end else begin
                        state_nx = ST_WR_SETUP;
                        tmr_load = 1'b1;
                        tmr_val  = SU_LOAD;
                    end
                end
            end
            ST_RD_WIN: begin
                if (tmr_expired) begin
                    cap_en   = 1'b1;
                    finish   = 1'b1;
                    state_nx = ST_RD_TURN;
                    tmr_load = 1'b1;
                    tmr_val  = TA_LOAD;
                end
            end
            ST_RD_TURN: begin
                if (tmr_expired) begin
                    state_nx = ST_IDLE;
                end
            end
            ST_WR_SETUP: begin
                if (tmr_expired) begin
                    state_nx = ST_WR_PULSE;
                    tmr_load = 1'b1;
                    tmr_val  = WE_LOAD;
                end
            end
            ST_WR_PULSE: begin
                if (tmr_expired) begin
                    state_nx = ST_WR_HOLD;
                    tmr_load = 1'b1;
                    tmr_val  = HD_LOAD;
                end
            end
            ST_WR_HOLD: begin
                if (tmr_expired) begin
                    finish   = 1'b1;
                    state_nx = ST_IDLE;
                end
            end
            default: state_nx = ST_IDLE;
        endcase
    end

    // State register and latched request.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            addr_q  <= '0;
            wdata_q <= '0;
            mask_q  <= '0;
        end else begin
            state_q <= state_nx;
            addr_q  <= addr_nx;
            wdata_q <= wdata_nx;
            mask_q  <= mask_nx;
        end
    end

    assign sel_nx = (state_nx == ST_RD_WIN)   || (state_nx == ST_WR_SETUP) ||
                    (state_nx == ST_WR_PULSE) || (state_nx == ST_WR_HOLD);

    // Registered RAM strobes, decoded from the next state.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sram_sel_n  <= 1'b1;
            sram_sel    <= 1'b0;
            sram_oe_n   <= 1'b1;
            sram_we_n   <= 1'b1;
            sram_be_n   <= '1;
            sram_addr   <= '0;
            sram_dq_out <= '0;
            sram_dq_oe  <= 1'b0;
            rsp_done    <= 1'b0;
        end else begin
            sram_sel_n  <= !sel_nx;
            sram_sel    <= sel_nx;
            sram_oe_n   <= !(state_nx == ST_RD_WIN);
            sram_we_n   <= !(state_nx == ST_WR_PULSE);
            sram_be_n   <= sel_nx ? ~mask_nx : '1;
            if (sel_nx) begin
                sram_addr <= addr_nx;
            end
            sram_dq_out <= wdata_nx;
            sram_dq_oe  <= (state_nx == ST_WR_SETUP) || (state_nx == ST_WR_PULSE) ||
                           (state_nx == ST_WR_HOLD);
            rsp_done    <= finish;
        end
    end

    sram_interval_timer #(.W(TMR_W)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .expired  (tmr_expired)
    );

    sram_lane_capture #(.LANES(LANES)) u_capture (
        .clk       (clk),
        .rst_n     (rst_n),
        .capture   (cap_en),
        .lane_mask (mask_q),
        .bus_in    (sram_dq_in),
        .word_out  (rsp_rdata)
    );
endmodule

// File: rtl/sram_bridge_sva.sv
module sram_bridge_sva
    import sram_bridge_pkg::*;
#(
    parameter int unsigned ADDR_W        = 20,
    parameter int unsigned LANES         = 2,
    parameter int unsigned CLK_PERIOD_PS = 10000
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_ready,
    input logic              rsp_done,
    input logic [ADDR_W-1:0] sram_addr,
    input logic              sram_sel_n,
    input logic              sram_sel,
    input logic              sram_oe_n,
    input logic              sram_we_n,
    input logic [LANES-1:0]  sram_be_n,
    input logic              sram_dq_oe
);
    localparam int unsigned RD_MIN = max_u(1, ps_to_cycles(T_READ_CYCLE_PS, CLK_PERIOD_PS));
    localparam int unsigned WE_MIN = ps_to_cycles(T_WE_PULSE_PS, CLK_PERIOD_PS);
    localparam int unsigned TA_MIN = max_u(1, ps_to_cycles(T_FLOAT_PS, CLK_PERIOD_PS));

    logic [7:0] oe_low_cnt, we_low_cnt, oe_high_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            oe_low_cnt  <= '0;
            we_low_cnt  <= '0;
            oe_high_cnt <= 8'hFF;
        end else begin
            oe_low_cnt  <= sram_oe_n  ? 8'd0 : (oe_low_cnt  == 8'hFF ? oe_low_cnt  : oe_low_cnt  + 8'd1);
            we_low_cnt  <= sram_we_n  ? 8'd0 : (we_low_cnt  == 8'hFF ? we_low_cnt  : we_low_cnt  + 8'd1);
            oe_high_cnt <= !sram_oe_n ? 8'd0 : (oe_high_cnt == 8'hFF ? oe_high_cnt : oe_high_cnt + 8'd1);
        end
    end

    assert_sel_pair_R2: assert property (@(posedge clk) disable iff (!rst_n)
        sram_sel_n == !sram_sel);

    assert_strobe_needs_sel_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!sram_oe_n || !sram_we_n) |-> (sram_sel && !sram_sel_n));

    assert_oe_we_exclusive_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !(!sram_oe_n && !sram_we_n));

    assert_read_window_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sram_oe_n) |-> (oe_low_cnt >= 8'(RD_MIN)));

    assert_read_addr_stable_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!sram_oe_n && $past(!sram_oe_n)) |-> $stable(sram_addr));

    assert_we_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sram_we_n) |-> (we_low_cnt >= 8'(WE_MIN)));

    assert_write_lanes_stable_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!sram_we_n && $past(!sram_we_n)) |-> ($stable(sram_be_n) && $stable(sram_addr)));

    assert_no_drive_on_read_R6: assert property (@(posedge clk) disable iff (!rst_n)
        sram_dq_oe |-> sram_oe_n);

    assert_turnaround_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sram_dq_oe) |-> (oe_high_cnt >= 8'(TA_MIN)));

    assert_zero_mask_no_we_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sram_we_n) |-> (sram_be_n != '1));

    assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_done |=> !rsp_done);

    assert_busy_not_ready_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_done || !sram_oe_n || !sram_we_n) |-> !req_ready);
endmodule

bind sram_bridge sram_bridge_sva #(
    .ADDR_W        (ADDR_W),
    .LANES         (DATA_W / 8),
    .CLK_PERIOD_PS (CLK_PERIOD_PS)
) u_sva (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_ready  (req_ready),
    .rsp_done   (rsp_done),
    .sram_addr  (sram_addr),
    .sram_sel_n (sram_sel_n),
    .sram_sel   (sram_sel),
    .sram_oe_n  (sram_oe_n),
    .sram_we_n  (sram_we_n),
    .sram_be_n  (sram_be_n),
    .sram_dq_oe (sram_dq_oe)
);

// File: tb/sram_bridge_test.sv
`timescale 1ns/1ps
module sram_bridge_test;
    localparam int unsigned PER_PS = 20000;
    localparam int unsigned EXP_RD = (55000 + PER_PS - 1) / PER_PS;
    localparam int unsigned EXP_WE = (40000 + PER_PS - 1) / PER_PS;
    localparam int unsigned EXP_SU = 1;
    localparam int unsigned EXP_HD = 1;
    localparam int unsigned EXP_WR = EXP_SU + EXP_WE + EXP_HD;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0, req_write = 1'b0;
    logic [19:0] req_addr = '0;
    logic [15:0] req_wdata = '0;
    logic [1:0]  req_mask = '0;
    logic        req_ready, rsp_done;
    logic [15:0] rsp_rdata;
    logic [19:0] sram_addr;
    logic        sram_sel_n, sram_sel, sram_oe_n, sram_we_n, sram_dq_oe;
    logic [1:0]  sram_be_n;
    logic [15:0] sram_dq_out, bus;

    int unsigned checks = 0, errors = 0, cyc = 0, we_falls = 0;

    always #10 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    sram_bridge #(.ADDR_W(20), .DATA_W(16), .CLK_PERIOD_PS(PER_PS)) uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
        .req_mask(req_mask), .rsp_done(rsp_done), .rsp_rdata(rsp_rdata),
        .sram_addr(sram_addr), .sram_sel_n(sram_sel_n), .sram_sel(sram_sel),
        .sram_oe_n(sram_oe_n), .sram_we_n(sram_we_n), .sram_be_n(sram_be_n),
        .sram_dq_out(sram_dq_out), .sram_dq_oe(sram_dq_oe), .sram_dq_in(bus)
    );

    task automatic check(input bit ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // ---------------- RAM model: 32 slots, tagged with the full address ----------
    logic [15:0] mem   [32];
    logic [19:0] tag   [32];
    logic        vld   [32];
    logic [14:0] hi_of [32];
    logic [15:0] ram_word;
    logic [1:0]  ram_drv;
    wire         ram_sel = !sram_sel_n && sram_sel;

    always_comb begin
        ram_word = (vld[sram_addr[4:0]] && tag[sram_addr[4:0]] == sram_addr) ?
                   mem[sram_addr[4:0]] : 16'hDEAD;
        for (int l = 0; l < 2; l++) begin
            ram_drv[l] = ram_sel && !sram_oe_n && sram_we_n && !sram_be_n[l];
            bus[8*l +: 8] = ram_drv[l] ? ram_word[8*l +: 8] :
                            (sram_dq_oe ? sram_dq_out[8*l +: 8] : 8'hA5);
        end
    end

    realtime t_addr = 0, t_data = 0, t_be = 0, t_sel = 0, t_oe_fall = 0;
    realtime t_oe_rise = -100.0, t_we_fall = 0;
    bit      we_low_seen = 0;

    always @(sram_addr)       t_addr = $realtime;
    always @(sram_dq_out)     t_data = $realtime;
    always @(sram_be_n)       t_be   = $realtime;
    always @(negedge sram_sel_n) t_sel = $realtime;
    always @(negedge sram_oe_n)  t_oe_fall = $realtime;

    always @(negedge sram_we_n) if (rst_n) begin
        t_we_fall = $realtime; we_low_seen = 1; we_falls++;
    end

    // Write end: interval checks (R5) and commit.
    always @(posedge sram_we_n) if (rst_n && we_low_seen) begin
        we_low_seen = 0;
        check($realtime - t_we_fall >= 40.0, "R5 we pulse ns", 32'($rtoi($realtime - t_we_fall)), 40);
        check($realtime - t_be  >= 45.0, "R5 lane to write end ns", 32'($rtoi($realtime - t_be)), 45);
        check($realtime - t_addr >= 40.0, "R5 addr setup ns", 32'($rtoi($realtime - t_addr)), 40);
        check($realtime - t_data >= 25.0, "R5 data setup ns", 32'($rtoi($realtime - t_data)), 25);
        check($realtime - t_sel >= 40.0, "R5 select to write end ns", 32'($rtoi($realtime - t_sel)), 40);
        check(sram_dq_oe && sram_oe_n, "R5 drivers on, oe high at write end",
              {sram_dq_oe, sram_oe_n}, 2'b11);
        if (ram_sel) begin
            for (int l = 0; l < 2; l++)
                if (!sram_be_n[l]) mem[sram_addr[4:0]][8*l +: 8] = bus[8*l +: 8];
            tag[sram_addr[4:0]] = sram_addr;
            vld[sram_addr[4:0]] = 1'b1;
        end
    end

    // Read end (R3) and turnaround before driving (R6).
    always @(posedge sram_oe_n) if (rst_n) begin
        t_oe_rise = $realtime;
        check($realtime - t_oe_fall >= 25.0, "R3 oe to data ns", 32'($rtoi($realtime - t_oe_fall)), 25);
        check($realtime - t_addr >= 55.0, "R3 addr to data ns", 32'($rtoi($realtime - t_addr)), 55);
    end
    always @(posedge sram_dq_oe) if (rst_n)
        check($realtime - t_oe_rise >= 20.0, "R6 turnaround ns", 32'($rtoi($realtime - t_oe_rise)), 20);

    // Contention and select rules, sampled away from the edge.
    always @(negedge clk) if (rst_n) begin
        if (sram_dq_oe && (ram_drv != 2'b00))
            check(0, "R6 bus contention", {ram_drv, sram_dq_oe}, 0);
        if ((!sram_oe_n || !sram_we_n) && !ram_sel)
            check(0, "R2 strobe without select", {sram_sel_n, sram_sel}, 2'b01);
    end

    // ---------------- reference and request tasks ----------------
    logic [15:0] ref_mem [32];

    function automatic logic [19:0] slot_addr(input int s);
        return {hi_of[s], 5'(s)};
    endfunction

    function automatic logic [15:0] expect_read(input int s, input logic [1:0] m);
        return {m[1] ? ref_mem[s][15:8] : 8'h00, m[0] ? ref_mem[s][7:0] : 8'h00};
    endfunction

    task automatic run_op(input bit wr, input int s, input logic [15:0] wd,
                          input logic [1:0] m, output logic [15:0] rd, output int lat);
        int t0;
        while (!req_ready) @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_addr = slot_addr(s);
        req_wdata = wd; req_mask = m;
        @(negedge clk);
        t0 = cyc;
        req_valid = 1'b0;
        while (!rsp_done) @(negedge clk);
        lat = cyc - t0;
        rd  = rsp_rdata;
        if (wr) for (int l = 0; l < 2; l++) if (m[l]) ref_mem[s][8*l +: 8] = wd[8*l +: 8];
        @(negedge clk);
        check(!rsp_done, "R8 done lasts one cycle", rsp_done, 0);
    endtask

    task automatic do_read(input int s, input logic [1:0] m, input string tagname);
        logic [15:0] rd; int lat;
        run_op(0, s, 16'h0, m, rd, lat);
        check(rd == expect_read(s, m), tagname, rd, expect_read(s, m));
        check(lat == EXP_RD, "R10 read latency", lat, EXP_RD);
    endtask

    task automatic do_write(input int s, input logic [15:0] wd, input logic [1:0] m);
        logic [15:0] rd; int lat;
        run_op(1, s, wd, m, rd, lat);
        check(lat == ((m == 2'b00) ? 0 : EXP_WR), "R10 write latency", lat,
              (m == 2'b00) ? 0 : EXP_WR);
    endtask

    // ---------------- watchdog ----------------
    initial begin
        repeat (150000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    // ---------------- main sequence ----------------
    initial begin
        int unsigned seed;
        int wf0;
        seed = $urandom(32'h1F2E3D4C);
        for (int s = 0; s < 32; s++) begin
            vld[s] = 1'b0; mem[s] = '0; tag[s] = '0; ref_mem[s] = '0;
            hi_of[s] = 15'($urandom);
        end
        hi_of[0]  = '0;
        hi_of[31] = '1;

        repeat (3) @(negedge clk);
        // R1: reset values held during reset
        check({sram_sel_n, sram_sel, sram_oe_n, sram_we_n, sram_be_n, sram_dq_oe, rsp_done} ==
              8'b10_11_11_0_0, "R1 reset strobes",
              {sram_sel_n, sram_sel, sram_oe_n, sram_we_n, sram_be_n, sram_dq_oe, rsp_done},
              8'b10_11_11_0_0);
        rst_n = 1'b1;
        @(negedge clk);
        check(req_ready && sram_sel_n && !sram_sel && !sram_dq_oe, "R1 after reset",
              {req_ready, sram_sel_n, sram_sel, sram_dq_oe}, 4'b1100);

        // R9: fill every slot with a full-mask write, read back (corner addresses included)
        for (int s = 0; s < 32; s++) do_write(s, 16'($urandom), 2'b11);
        for (int s = 0; s < 32; s++) do_read(s, 2'b11, "R9 full read-back");

        // R4: single-lane reads return zero on the unselected lane
        do_read(3, 2'b01, "R4 lower-lane read");
        do_read(3, 2'b10, "R4 upper-lane read");
        do_read(3, 2'b00, "R4 no-lane read");

        // R9: partial writes merge
        do_write(7, 16'hBEEF, 2'b10);
        do_read(7, 2'b11, "R9 upper-lane merge");
        do_write(7, 16'h1234, 2'b01);
        do_read(7, 2'b11, "R9 lower-lane merge");

        // R7: zero-mask write never strobes and leaves contents
        wf0 = we_falls;
        do_write(9, 16'h5A5A, 2'b00);
        check(we_falls == wf0, "R7 no write strobe", we_falls - wf0, 0);
        do_read(9, 2'b11, "R7 contents unchanged");

        // R8: request while busy is ignored
        while (!req_ready) @(negedge clk);
        req_valid = 1'b1; req_write = 1'b0; req_addr = slot_addr(12); req_mask = 2'b11;
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b1; req_addr = slot_addr(12);
        req_wdata = ~ref_mem[12]; req_mask = 2'b11;
        check(!req_ready, "R8 not ready while busy", req_ready, 0);
        @(negedge clk);
        req_valid = 1'b0;
        while (!rsp_done) @(negedge clk);
        check(rsp_rdata == ref_mem[12], "R8 read during ignored request", rsp_rdata, ref_mem[12]);
        @(negedge clk);
        do_read(12, 2'b11, "R8 busy request had no effect");

        // Random back-to-back traffic (R3 R5 R6 R9)
        for (int i = 0; i < 400; i++) begin
            int s;
            logic [1:0] m;
            s = int'($urandom % 32);
            m = 2'($urandom);
            if ($urandom % 2) do_write(s, 16'($urandom), m);
            else do_read(s, m, "R9 random read-back");
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule